// File: doc/BRIEF.md
# Peripheral clock and reset sequencer

This block is a register-mapped controller that owns the clock enables and active-low resets of four peripheral domains: a graphics domain with seven independent sub-block resets and one shared clock enable, a main-memory domain with reset, clock enable and a clock acknowledge, a DSP domain with reset and clock enable, and a video-decoder domain with a reset only. Software writes the reset and clock bits through a simple word-addressed write port. A reset bit of 0 means "hold in reset". A reset bit of 1 means "release".

Asserting a reset takes effect at once. Releasing one is delayed. Each reset output sits behind a release timer with three states: `REL_HOLD` (output low), `REL_COUNT` (release requested, minimum hold counting) and `REL_RUN` (output high). These are the timer's transitions:
- `REL_HOLD`→`REL_COUNT` when the release request is seen and allowed.
- `REL_COUNT`→`REL_RUN` when the count expires.
- `REL_COUNT`→`REL_HOLD` when the request is withdrawn.
- `REL_RUN`→`REL_HOLD` when software writes the bit back to 0.

The memory clock uses a handshake machine with two states: `HS_STABLE` (the acknowledge equals the request) and `HS_PENDING` (a change is in flight). It moves `HS_STABLE`→`HS_PENDING` when the clock request changes. It moves back `HS_PENDING`→`HS_STABLE` when the latency elapses and the acknowledge takes the new value, or earlier if the request returns to the acknowledged value. The memory reset timer may leave `REL_HOLD` only while the acknowledge matches the clock request. To power memory down, software writes 0 and then 1 and polls the acknowledge bit until it clears.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, the graphics, memory and DSP registers read 0 and the video-decoder register reads 1. The graphics, memory and DSP resets and all clock enables are low, and `vdec_rst_n` is high.
- R2: The graphics register at address 0 holds seven independent reset bits in bits 0–6. A bit written from 0 to 1 raises its `gfx_rst_n` bit exactly GFX_HOLD (12) clock edges after the write edge.
- R3: Graphics register bit 16 drives `gfx_clk_en` from the edge after the write. Written values in bits 7–15 and 17–31 are discarded and read back as 0.
- R4: Writing 0 to any reset bit drives the matching reset output low in the cycle right after the write edge, with no delay.
- R5: While a release is counting, the register reads back the requested value, yet the reset output stays low.
- R6: Memory register (address 1) bit 1 is the clock enable and drives `mem_clk_en` at once. Read-only bit 2 takes the value of bit 1 exactly MEM_ACK_LAT (3) edges after the clock bit changes. Writes to bit 2 are ignored.
- R7: Memory register bit 0 is the reset. A release raises `mem_rst_n` MEM_HOLD (4) edges after the edge at which the acknowledge comes to match the clock request, and never while they differ.
- R8: DSP register (address 2) bit 1 drives `dsp_clk_en`. A release of bit 0 raises `dsp_rst_n` DSP_HOLD (48) edges after the write edge.
- R9: Video-decoder register (address 3) bit 0 resets to 1. A release after a write of 0 raises `vdec_rst_n` VDEC_HOLD (16) edges after the write edge.
- R10: Withdrawing a release during the count aborts it. The next release counts the full delay again from its own write.
- R11: Writes to addresses 4–7 change no register and no output, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Write strobe for the register addressed by `addr` |
| addr | input | 3 | Word address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at `addr` (combinational) |
| gfx_rst_n | output | 7 | Graphics sub-block resets, active low |
| gfx_clk_en | output | 1 | Shared graphics clock enable |
| mem_rst_n | output | 1 | Main-memory reset, active low |
| mem_clk_en | output | 1 | Main-memory clock request |
| dsp_rst_n | output | 1 | DSP reset, active low |
| dsp_clk_en | output | 1 | DSP clock enable |
| vdec_rst_n | output | 1 | Video-decoder reset, active low |

## Verification
The bench times each reset release to the exact edge, checking the cycle before the release as well as the cycle of it. An off-by-one counter or a release taken straight from the register bit would show up as a high output one edge too early or too late. It aborts a graphics release halfway through and checks that the output is still low at the edge where the first count would have expired, which catches a counter that only pauses instead of restarting. It walks the memory power-down sequence, polling the acknowledge and writing a 1 into the read-only acknowledge position. A handshake with the wrong latency, a writable acknowledge, or a memory reset that ignores the handshake would each give a wrong readback or an early `mem_rst_n`. Writes with junk in the unused graphics bits and at unmapped addresses confirm that nothing leaks into state or outputs.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int GFX_NRST    = 7;
    localparam int GFX_CLK_BIT = 16;

    localparam logic [ADDR_W-1:0] A_GFX  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MEM  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DSP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_VDEC = 3'd3;

    typedef enum logic [1:0] {
        REL_HOLD  = 2'd0,
        REL_COUNT = 2'd1,
        REL_RUN   = 2'd2
    } rel_state_e;

    typedef enum logic {
        HS_STABLE  = 1'b0,
        HS_PENDING = 1'b1
    } hs_state_e;

endpackage

// File: rtl/pwr_rel_timer.sv
module pwr_rel_timer
    import pwr_seq_pkg::*;
#(
    parameter int DELAY    = 12,
    parameter bit INIT_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic allow_i,
    output logic rst_n_o
);
    localparam int CW = $clog2(DELAY + 1);
    localparam rel_state_e INIT_ST = INIT_RUN ? REL_RUN : REL_HOLD;

    rel_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          go;

    assign go = req_i && allow_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT_ST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            REL_HOLD: begin
                if (go) begin
                    if (DELAY <= 1) begin
                        state_d = REL_RUN;
                    end else begin
                        state_d = REL_COUNT;
                        cnt_d   = CW'(1);
                    end
                end
            end
            REL_COUNT: begin
                if (!go) begin
                    state_d = REL_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(DELAY - 1)) begin
                    state_d = REL_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            REL_RUN: begin
                if (!req_i) state_d = REL_HOLD;
            end
            default: begin
                state_d = REL_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        rst_n_o = (state_q == REL_RUN) && req_i;
    end

    // Checker: consecutive cycles with release requested and allowed
    logic [CW-1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               age_q <= INIT_RUN ? CW'(DELAY) : '0;
        else if (!go)             age_q <= '0;
        else if (age_q != CW'(DELAY)) age_q <= age_q + CW'(1);
    end

    // R2: an output rises only after the full hold of requested cycles
    p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n_o) |-> (age_q >= CW'(DELAY)));

    // R2: the counter never runs past its limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REL_COUNT) |-> (cnt_q < CW'(DELAY)));

endmodule

// File: rtl/pwr_clk_hs.sv
module pwr_clk_hs
    import pwr_seq_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ack_o
);
    localparam int CW = $clog2(LAT + 1);

    hs_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ack_q, ack_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_STABLE;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ack_q   <= ack_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ack_d   = ack_q;
        unique case (state_q)
            HS_STABLE: begin
                if (req_i != ack_q) begin
                    state_d = HS_PENDING;
                    cnt_d   = CW'(1);
                end
            end
            HS_PENDING: begin
                if (req_i == ack_q) begin
                    state_d = HS_STABLE;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(LAT - 1)) begin
                    state_d = HS_STABLE;
                    cnt_d   = '0;
                    ack_d   = req_i;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = HS_STABLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        ack_o = ack_q;
    end

    // R6: the acknowledge only moves toward a differing request
    p_ack_toward_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != $past(ack_o)) |-> ($past(req_i) != $past(ack_o)));

endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
    import pwr_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                mem_ack_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [GFX_NRST-1:0] gfx_rst_q,
    output logic                gfx_clk_q,
    output logic                mem_rst_q,
    output logic                mem_clk_q,
    output logic                dsp_rst_q,
    output logic                dsp_clk_q,
    output logic                vdec_rst_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gfx_rst_q  <= '0;
            gfx_clk_q  <= 1'b0;
            mem_rst_q  <= 1'b0;
            mem_clk_q  <= 1'b0;
            dsp_rst_q  <= 1'b0;
            dsp_clk_q  <= 1'b0;
            vdec_rst_q <= 1'b1;
        end else if (wr_en_i) begin
            case (addr_i)
                A_GFX: begin
                    gfx_rst_q <= wdata_i[GFX_NRST-1:0];
                    gfx_clk_q <= wdata_i[GFX_CLK_BIT];
                end
                A_MEM: begin
                    mem_rst_q <= wdata_i[0];
                    mem_clk_q <= wdata_i[1];
                end
                A_DSP: begin
                    dsp_rst_q <= wdata_i[0];
                    dsp_clk_q <= wdata_i[1];
                end
                A_VDEC: begin
                    vdec_rst_q <= wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_GFX: begin
                rdata_o[GFX_NRST-1:0] = gfx_rst_q;
                rdata_o[GFX_CLK_BIT]  = gfx_clk_q;
            end
            A_MEM:   rdata_o[2:0] = {mem_ack_i, mem_clk_q, mem_rst_q};
            A_DSP:   rdata_o[1:0] = {dsp_clk_q, dsp_rst_q};
            A_VDEC:  rdata_o[0]   = vdec_rst_q;
            default: rdata_o = '0;
        endcase
    end

    // R3: junk in the unused graphics bits leaves the clock enable as written
    p_unused_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_GFX && (|wdata_i[DATA_W-1:GFX_NRST]))
        |=> (gfx_clk_q == $past(wdata_i[GFX_CLK_BIT])));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int GFX_HOLD    = 12,
    parameter int MEM_HOLD    = 4,
    parameter int MEM_ACK_LAT = 3,
    parameter int DSP_HOLD    = 48,
    parameter int VDEC_HOLD   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [GFX_NRST-1:0] gfx_rst_n,
    output logic                gfx_clk_en,
    output logic                mem_rst_n,
    output logic                mem_clk_en,
    output logic                dsp_rst_n,
    output logic                dsp_clk_en,
    output logic                vdec_rst_n
);
    logic [GFX_NRST-1:0] gfx_rst_q;
    logic gfx_clk_q, mem_rst_q, mem_clk_q, dsp_rst_q, dsp_clk_q, vdec_rst_q;
    logic mem_ack;
    logic mem_match;

    pwr_seq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .mem_ack_i  (mem_ack),
        .rdata_o    (rdata),
        .gfx_rst_q  (gfx_rst_q),
        .gfx_clk_q  (gfx_clk_q),
        .mem_rst_q  (mem_rst_q),
        .mem_clk_q  (mem_clk_q),
        .dsp_rst_q  (dsp_rst_q),
        .dsp_clk_q  (dsp_clk_q),
        .vdec_rst_q (vdec_rst_q)
    );

    for (genvar g = 0; g < GFX_NRST; g++) begin : g_gfx
        pwr_rel_timer #(.DELAY(GFX_HOLD), .INIT_RUN(1'b0)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (gfx_rst_q[g]),
            .allow_i (1'b1),
            .rst_n_o (gfx_rst_n[g])
        );
    end

    pwr_clk_hs #(.LAT(MEM_ACK_LAT)) u_mem_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (mem_clk_q),
        .ack_o (mem_ack)
    );

    assign mem_match = (mem_ack == mem_clk_q);

    pwr_rel_timer #(.DELAY(MEM_HOLD), .INIT_RUN(1'b0)) u_mem_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (mem_rst_q),
        .allow_i (mem_match),
        .rst_n_o (mem_rst_n)
    );

    pwr_rel_timer #(.DELAY(DSP_HOLD), .INIT_RUN(1'b0)) u_dsp_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (dsp_rst_q),
        .allow_i (1'b1),
        .rst_n_o (dsp_rst_n)
    );

    pwr_rel_timer #(.DELAY(VDEC_HOLD), .INIT_RUN(1'b1)) u_vdec_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (vdec_rst_q),
        .allow_i (1'b1),
        .rst_n_o (vdec_rst_n)
    );

    assign gfx_clk_en = gfx_clk_q;
    assign mem_clk_en = mem_clk_q;
    assign dsp_clk_en = dsp_clk_q;

    // R7: memory leaves reset only after a cycle where acknowledge matched request
    p_mem_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rst_n) |-> ($past(mem_ack) == $past(mem_clk_q)));

endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    import pwr_seq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [6:0]        gfx_rst_n;
    logic gfx_clk_en, mem_rst_n, mem_clk_en, dsp_rst_n, dsp_clk_en, vdec_rst_n;

    pwr_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .gfx_rst_n(gfx_rst_n), .gfx_clk_en(gfx_clk_en),
        .mem_rst_n(mem_rst_n), .mem_clk_en(mem_clk_en), .dsp_rst_n(dsp_rst_n),
        .dsp_clk_en(dsp_clk_en), .vdec_rst_n(vdec_rst_n)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int due; int sel; int exp; string tag; } item_t;
    item_t sb[$];

    localparam int S_GFX_RST = 0, S_GFX_CLK = 1, S_MEM_RST = 2, S_MEM_CLK = 3,
                   S_DSP_RST = 4, S_DSP_CLK = 5, S_VDEC_RST = 6;

    function automatic int peek(int sel);
        case (sel)
            S_GFX_RST:  return int'(gfx_rst_n);
            S_GFX_CLK:  return int'(gfx_clk_en);
            S_MEM_RST:  return int'(mem_rst_n);
            S_MEM_CLK:  return int'(mem_clk_en);
            S_DSP_RST:  return int'(dsp_rst_n);
            S_DSP_CLK:  return int'(dsp_clk_en);
            default:    return int'(vdec_rst_n);
        endcase
    endfunction

    task automatic expect_out(int sel, int due, int exp, string tag);
        item_t it;
        it.due = due; it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: pops due items a little after each falling edge
    always @(negedge clk) begin
        #2;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                n_chk++;
                if (sb[i].due < cyc || peek(sb[i].sel) != sb[i].exp) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d output %0d: actual %0h expected %0h",
                             sb[i].tag, cyc, sb[i].sel, peek(sb[i].sel), sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, output int w);
        wr_en = 1'b1; addr = a; wdata = d;
        w = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
        addr = a;
        #1;
        n_chk++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read addr %0d: actual %08h expected %08h", tag, a, rdata, exp);
        end
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        int w, w2, w3, w4, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_out(S_GFX_RST, cyc, 0, "R1");
        expect_out(S_GFX_CLK, cyc, 0, "R1");
        expect_out(S_MEM_RST, cyc, 0, "R1");
        expect_out(S_MEM_CLK, cyc, 0, "R1");
        expect_out(S_DSP_RST, cyc, 0, "R1");
        expect_out(S_DSP_CLK, cyc, 0, "R1");
        expect_out(S_VDEC_RST, cyc, 1, "R1");
        rd(A_GFX, 32'h0, "R1");
        rd(A_MEM, 32'h0, "R1");
        rd(A_DSP, 32'h0, "R1");
        rd(A_VDEC, 32'h1, "R1");

        // R2/R3/R5: release bits 0 and 2 with junk in unused bits
        wr(A_GFX, 32'h0001_FF85, w);
        expect_out(S_GFX_CLK, w, 1, "R3");
        expect_out(S_GFX_RST, w + 11, 7'h00, "R2");
        expect_out(S_GFX_RST, w + 12, 7'h05, "R2");
        rd(A_GFX, 32'h0001_0005, "R3");
        expect_out(S_GFX_RST, w + 1, 7'h00, "R5");
        @(negedge clk);
        rd(A_GFX, 32'h0001_0005, "R5");
        wait_until(w + 13);

        // R4: assertion of one graphics reset is immediate
        wr(A_GFX, 32'h0001_0004, w2);
        expect_out(S_GFX_RST, w2, 7'h04, "R4");
        expect_out(S_GFX_CLK, w2, 1, "R4");
        wait_until(w2 + 2);

        // R10: abort a release halfway, then restart it
        wr(A_GFX, 32'h0001_0005, w3);
        repeat (4) @(negedge clk);
        wr(A_GFX, 32'h0001_0004, t);
        wr(A_GFX, 32'h0001_0005, w4);
        expect_out(S_GFX_RST, w3 + 12, 7'h04, "R10");
        expect_out(S_GFX_RST, w4 + 11, 7'h04, "R10");
        expect_out(S_GFX_RST, w4 + 12, 7'h05, "R10");
        wait_until(w4 + 13);

        // R11: unmapped address
        wr(3'd5, 32'hFFFF_FFFF, w);
        rd(3'd5, 32'h0, "R11");
        rd(A_GFX, 32'h0001_0005, "R11");
        expect_out(S_GFX_RST, w + 1, 7'h05, "R11");
        expect_out(S_GFX_CLK, w + 1, 1, "R11");
        wait_until(w + 2);

        // R6/R7: memory power-up through the handshake
        wr(A_MEM, 32'h3, w);
        expect_out(S_MEM_CLK, w, 1, "R6");
        expect_out(S_MEM_RST, w + 6, 0, "R7");
        expect_out(S_MEM_RST, w + 7, 1, "R7");
        rd(A_MEM, 32'h3, "R5");
        repeat (2) @(negedge clk);
        rd(A_MEM, 32'h3, "R6");
        @(negedge clk);
        rd(A_MEM, 32'h7, "R6");
        wait_until(w + 8);

        // R6/R7: memory power-down: write 0 then 1 (bit 2 set, ignored), poll ack
        wr(A_MEM, 32'h0, w);
        expect_out(S_MEM_RST, w, 0, "R4");
        expect_out(S_MEM_CLK, w, 0, "R6");
        wr(A_MEM, 32'h5, t);
        rd(A_MEM, 32'h5, "R6");
        @(negedge clk);
        rd(A_MEM, 32'h5, "R6");
        @(negedge clk);
        rd(A_MEM, 32'h1, "R6");
        expect_out(S_MEM_RST, w + 6, 0, "R7");
        expect_out(S_MEM_RST, w + 7, 1, "R7");
        wait_until(w + 8);

        // R8: DSP release
        wr(A_DSP, 32'h3, w);
        expect_out(S_DSP_CLK, w, 1, "R8");
        expect_out(S_DSP_RST, w + 47, 0, "R8");
        expect_out(S_DSP_RST, w + 48, 1, "R8");
        rd(A_DSP, 32'h3, "R8");
        wait_until(w + 49);

        // R9: video decoder assert then release
        wr(A_VDEC, 32'h0, w);
        expect_out(S_VDEC_RST, w, 0, "R9");
        wr(A_VDEC, 32'h1, w2);
        rd(A_VDEC, 32'h1, "R9");
        expect_out(S_VDEC_RST, w2 + 15, 0, "R9");
        expect_out(S_VDEC_RST, w2 + 16, 1, "R9");
        wait_until(w2 + 17);

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule